// File: doc/BRIEF.md
# Triggered Debug Capture Unit

This block is a single on-chip trace capture unit for observing internal logic while the chip runs at speed. A wide probe bus is split into equal-width groups, and a runtime select picks one of them. The chosen group feeds two programmable comparators, one deciding when capture starts (the trigger) and one deciding which samples are kept (the qualifier). Kept samples land in a local sample buffer that software reads back through a small address/data register pair.

Each capture window holds a programmable number of qualified samples. In single-shot mode the unit stops after one window. In repeat mode it re-arms after every window and appends the next window behind the previous one, so that short bursts spread over a long run can be collected until the buffer fills. All settings sit in registers that may be rewritten while the design runs, and an enable bit switches the unit on and off.

Top module: `dbg_capture_unit`

## Requirements
- R1: The probe bus holds GROUPS groups of GW bits, group g occupying bits g*GW to g*GW+GW-1; the select register (address 1) chooses the group that feeds both comparators and the buffer.
- R2: From the armed state, capture begins in the cycle whose sample meets the trigger condition; samples before that cycle are never stored, and the triggering sample itself is stored when it is qualified.
- R3: Each comparator masks the selected group with its mask register and compares the unsigned result with operand A (and B); the operation codes are 0 equal, 1 not equal, 2 less than A, 3 greater than A, 4 inside A..B inclusive, 5 outside A..B (exact complement of 4), 6 always true, 7 never true.
- R4: Once capture has begun, a sample is written only in cycles where the qualification condition holds, and only written samples count toward the window length.
- R5: A window closes after the window-length register (address 2, 0 treated as 1) worth of qualified samples and increments the completed-window count; single-shot then returns to idle, repeat mode returns to armed and appends later windows after earlier ones.
- R6: When the write pointer reaches the buffer depth the unit enters the full state and writes nothing more until cleared, even in the middle of a window.
- R7: Writing the control register with the enable bit (bit 0) set moves an idle unit to armed (or to full if the buffer is already full); while the enable bit is 0 the unit stays idle and neither triggers nor writes.
- R8: Software sets the read address (address 9) and reads the addressed sample from address 10 two cycles later; the data reads as 0 unless the state is idle or full.
- R9: Writing the control register with bit 2 set clears the write pointer, the window count and the window progress and returns the unit to idle.
- R10: Register map: 0 control (bit0 enable, bit1 repeat, bit2 clear, bits 6:4 trigger op, bits 10:8 qualifier op), 1 select, 2 window length, 3/4/5 trigger mask/A/B, 6/7/8 qualifier mask/A/B, 9 read address, 10 read data, 11 state (0 idle, 1 armed, 2 capturing, 3 full), 12 write pointer, 13 completed windows.
- R11: After reset the state, write pointer and window count are 0, the window length reads 1 and the control register reads 0x600 (trigger op equal, qualifier op always, unit disabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe | input | GROUPS*GW | Probe bus, all groups side by side |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |

## Verification
The checker watches, on every cycle, that nothing reaches the buffer from the idle or full states or from an armed cycle without a trigger, that every buffer write has a true qualifier and advances the pointer by exactly one, that the pointer never passes the depth and that the full state holds while enabled. What only the scenarios can show is the content and order of the stored samples: the group select, each comparator code at its edges, appended windows in repeat mode, the stop at depth, the read gating and the effect of clear and disable on the visible counters.

// File: rtl/dbg_cap_pkg.sv
package dbg_cap_pkg;

   typedef enum logic [2:0] {
      OP_EQ     = 3'd0,
      OP_NE     = 3'd1,
      OP_LT     = 3'd2,
      OP_GT     = 3'd3,
      OP_INSIDE = 3'd4,
      OP_OUTSIDE= 3'd5,
      OP_ALWAYS = 3'd6,
      OP_NEVER  = 3'd7
   } cmp_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_CAPT  = 2'd2,
      ST_FULL  = 2'd3
   } cap_state_e;

   localparam logic [3:0] RA_CTRL   = 4'd0;
   localparam logic [3:0] RA_GSEL   = 4'd1;
   localparam logic [3:0] RA_WLEN   = 4'd2;
   localparam logic [3:0] RA_TMASK  = 4'd3;
   localparam logic [3:0] RA_TA     = 4'd4;
   localparam logic [3:0] RA_TB     = 4'd5;
   localparam logic [3:0] RA_QMASK  = 4'd6;
   localparam logic [3:0] RA_QA     = 4'd7;
   localparam logic [3:0] RA_QB     = 4'd8;
   localparam logic [3:0] RA_RADDR  = 4'd9;
   localparam logic [3:0] RA_RDATA  = 4'd10;
   localparam logic [3:0] RA_STATE  = 4'd11;
   localparam logic [3:0] RA_WPTR   = 4'd12;
   localparam logic [3:0] RA_WCOUNT = 4'd13;

endpackage

// File: rtl/dbg_cond_cmp.sv
module dbg_cond_cmp
   import dbg_cap_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] sample,
   input  cmp_op_e      op,
   input  logic [W-1:0] mask,
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   output logic         hit
);

   logic [W-1:0] val;
   logic         in_rng;

   assign val    = sample & mask;
   assign in_rng = (val >= opa) && (val <= opb);

   always_comb begin
      unique case (op)
         OP_EQ:      hit = (val == opa);
         OP_NE:      hit = (val != opa);
         OP_LT:      hit = (val <  opa);
         OP_GT:      hit = (val >  opa);
         OP_INSIDE:  hit = in_rng;
         OP_OUTSIDE: hit = !in_rng;
         OP_ALWAYS:  hit = 1'b1;
         default:    hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/dbg_group_sel.sv
module dbg_group_sel #(
   parameter int GROUPS = 16,
   parameter int GW     = 16,
   parameter int SW     = 4
) (
   input  logic [GROUPS*GW-1:0] probe,
   input  logic [SW-1:0]        sel,
   output logic [GW-1:0]        grp
);

   generate
      if (GROUPS == 1) begin : g_single
         assign grp = probe;
      end else begin : g_mux
         always_comb begin
            grp = '0;
            for (int g = 0; g < GROUPS; g++) begin
               if (sel == SW'(g)) grp = probe[g*GW +: GW];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dbg_sample_ram.sv
module dbg_sample_ram #(
   parameter int DEPTH = 2048,
   parameter int W     = 16,
   parameter int AW    = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   input  logic          rd_ok,
   output logic [W-1:0]  rdata
);

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_ok) rdata <= mem[raddr];
      else            rdata <= '0;
   end

endmodule

// File: rtl/dbg_capture_ctl.sv
module dbg_capture_ctl
   import dbg_cap_pkg::*;
#(
   parameter int DEPTH = 2048,
   parameter int WLW   = 16,
   parameter int WCW   = 16,
   parameter int PW    = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           arm,
   input  logic           clr,
   input  logic           en,
   input  logic           rpt,
   input  logic [WLW-1:0] wlen,
   input  logic           trig_hit,
   input  logic           qual_hit,
   output cap_state_e     state,
   output logic [PW-1:0]  wptr,
   output logic [WCW-1:0] wcount,
   output logic           wr_en
);

   localparam logic [PW-1:0] PTR_END = PW'(DEPTH);

   logic [WLW-1:0] scnt;
   logic [WLW-1:0] wlen_eff;
   logic           in_win;
   logic           win_done;
   logic           fill;

   assign wlen_eff = (wlen == '0) ? WLW'(1) : wlen;
   assign in_win   = en && !clr &&
                     ((state == ST_ARMED && trig_hit) || state == ST_CAPT);
   assign wr_en    = in_win && qual_hit;
   assign win_done = wr_en && ((scnt + WLW'(1)) == wlen_eff);
   assign fill     = wr_en && ((wptr + PW'(1)) == PTR_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         wptr   <= '0;
         wcount <= '0;
         scnt   <= '0;
      end else if (clr) begin
         state  <= ST_IDLE;
         wptr   <= '0;
         wcount <= '0;
         scnt   <= '0;
      end else if (state == ST_IDLE) begin
         if (arm) begin
            state <= (wptr == PTR_END) ? ST_FULL : ST_ARMED;
            scnt  <= '0;
         end
      end else if (!en) begin
         state <= ST_IDLE;
         scnt  <= '0;
      end else begin
         if (wr_en) begin
            wptr <= wptr + PW'(1);
            scnt <= win_done ? '0 : scnt + WLW'(1);
         end
         if (win_done) wcount <= wcount + WCW'(1);
         if (fill)          state <= ST_FULL;
         else if (win_done) state <= rpt ? ST_ARMED : ST_IDLE;
         else if (in_win)   state <= ST_CAPT;
      end
   end

endmodule

// File: rtl/dbg_capture_unit.sv
module dbg_capture_unit
   import dbg_cap_pkg::*;
#(
   parameter int GROUPS = 16,
   parameter int GW     = 16,
   parameter int DEPTH  = 2048,
   parameter int WLW    = 16,
   parameter int WCW    = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [GROUPS*GW-1:0] probe,
   input  logic                 cfg_we,
   input  logic [3:0]           cfg_addr,
   input  logic [31:0]          cfg_wdata,
   output logic [31:0]          cfg_rdata
);

   localparam int SW    = (GROUPS > 1) ? $clog2(GROUPS) : 1;
   localparam int AW    = $clog2(DEPTH);
   localparam int PW    = $clog2(DEPTH + 1);
   localparam int NCOND = 2;

   generate
      if (GW < 1 || GW > 32)   begin : g_bad_gw    $error("GW must be 1..32");        end
      if (GROUPS < 1)          begin : g_bad_grp   $error("GROUPS must be >= 1");     end
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
                               begin : g_bad_depth $error("DEPTH must be 2^n, n>=1"); end
      if (WLW > 32 || WCW > 32 || PW > 32)
                               begin : g_bad_cnt   $error("counter wider than 32");   end
   endgenerate

   // configuration registers
   logic            en_q, rpt_q;
   cmp_op_e         c_op   [NCOND];
   logic [SW-1:0]   gsel_q;
   logic [WLW-1:0]  wlen_q;
   logic [GW-1:0]   c_mask [NCOND];
   logic [GW-1:0]   c_a    [NCOND];
   logic [GW-1:0]   c_b    [NCOND];
   logic [AW-1:0]   raddr_q;

   logic            arm_p, clr_p;
   logic [GW-1:0]   sample;
   logic [NCOND-1:0] c_hit;
   logic            trig_hit, qual_hit;
   cap_state_e      state;
   logic [1:0]      st_bits;
   logic [PW-1:0]   wptr;
   logic [WCW-1:0]  wcount;
   logic            wr_en;
   logic            rd_ok;
   logic [GW-1:0]   rd_word;

   assign arm_p = cfg_we && (cfg_addr == RA_CTRL) && cfg_wdata[0];
   assign clr_p = cfg_we && (cfg_addr == RA_CTRL) && cfg_wdata[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         rpt_q   <= 1'b0;
         c_op[0] <= OP_EQ;
         c_op[1] <= OP_ALWAYS;
         gsel_q  <= '0;
         wlen_q  <= WLW'(1);
         raddr_q <= '0;
         for (int c = 0; c < NCOND; c++) begin
            c_mask[c] <= '1;
            c_a[c]    <= '0;
            c_b[c]    <= '1;
         end
      end else if (cfg_we) begin
         unique case (cfg_addr)
            RA_CTRL: begin
               en_q    <= cfg_wdata[0];
               rpt_q   <= cfg_wdata[1];
               c_op[0] <= cmp_op_e'(cfg_wdata[6:4]);
               c_op[1] <= cmp_op_e'(cfg_wdata[10:8]);
            end
            RA_GSEL:  gsel_q    <= cfg_wdata[SW-1:0];
            RA_WLEN:  wlen_q    <= cfg_wdata[WLW-1:0];
            RA_TMASK: c_mask[0] <= cfg_wdata[GW-1:0];
            RA_TA:    c_a[0]    <= cfg_wdata[GW-1:0];
            RA_TB:    c_b[0]    <= cfg_wdata[GW-1:0];
            RA_QMASK: c_mask[1] <= cfg_wdata[GW-1:0];
            RA_QA:    c_a[1]    <= cfg_wdata[GW-1:0];
            RA_QB:    c_b[1]    <= cfg_wdata[GW-1:0];
            RA_RADDR: raddr_q   <= cfg_wdata[AW-1:0];
            default: ;
         endcase
      end
   end

   dbg_group_sel #(.GROUPS(GROUPS), .GW(GW), .SW(SW)) u_sel (
      .probe (probe),
      .sel   (gsel_q),
      .grp   (sample)
   );

   // condition 0 starts capture, condition 1 qualifies samples
   for (genvar c = 0; c < NCOND; c++) begin : g_cond
      dbg_cond_cmp #(.W(GW)) u_cmp (
         .sample (sample),
         .op     (c_op[c]),
         .mask   (c_mask[c]),
         .opa    (c_a[c]),
         .opb    (c_b[c]),
         .hit    (c_hit[c])
      );
   end

   assign trig_hit = c_hit[0];
   assign qual_hit = c_hit[1];

   dbg_capture_ctl #(.DEPTH(DEPTH), .WLW(WLW), .WCW(WCW), .PW(PW)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (arm_p),
      .clr      (clr_p),
      .en       (en_q),
      .rpt      (rpt_q),
      .wlen     (wlen_q),
      .trig_hit (trig_hit),
      .qual_hit (qual_hit),
      .state    (state),
      .wptr     (wptr),
      .wcount   (wcount),
      .wr_en    (wr_en)
   );

   assign st_bits = state;
   assign rd_ok   = (state == ST_IDLE) || (state == ST_FULL);

   dbg_sample_ram #(.DEPTH(DEPTH), .W(GW), .AW(AW)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .waddr (wptr[AW-1:0]),
      .wdata (sample),
      .raddr (raddr_q),
      .rd_ok (rd_ok),
      .rdata (rd_word)
   );

   always_comb begin
      unique case (cfg_addr)
         RA_CTRL:   cfg_rdata = {21'd0, 1'b0, c_op[1], 1'b0, c_op[0], 2'b00, rpt_q, en_q};
         RA_GSEL:   cfg_rdata = 32'(gsel_q);
         RA_WLEN:   cfg_rdata = 32'(wlen_q);
         RA_TMASK:  cfg_rdata = 32'(c_mask[0]);
         RA_TA:     cfg_rdata = 32'(c_a[0]);
         RA_TB:     cfg_rdata = 32'(c_b[0]);
         RA_QMASK:  cfg_rdata = 32'(c_mask[1]);
         RA_QA:     cfg_rdata = 32'(c_a[1]);
         RA_QB:     cfg_rdata = 32'(c_b[1]);
         RA_RADDR:  cfg_rdata = 32'(raddr_q);
         RA_RDATA:  cfg_rdata = 32'(rd_word);
         RA_STATE:  cfg_rdata = 32'(st_bits);
         RA_WPTR:   cfg_rdata = 32'(wptr);
         RA_WCOUNT: cfg_rdata = 32'(wcount);
         default:   cfg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/dbg_capture_chk.sv
module dbg_capture_chk #(
   parameter int DEPTH = 2048,
   parameter int PW    = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    state,
   input logic [PW-1:0] wptr,
   input logic          wr_en,
   input logic          trig_hit,
   input logic          qual_hit,
   input logic          en
);

   AST_PTR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      wptr <= PW'(DEPTH));                                               // R6

   AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd3 && en) |=> (state == 2'd3 || wptr == '0));          // R6

   AST_WR_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> qual_hit);                                               // R4

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> wptr == $past(wptr) + PW'(1));                           // R4

   AST_NO_PRETRIG_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd1 && !trig_hit) |-> !wr_en);                          // R2

   AST_IDLE_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd0 || state == 2'd3) |-> !wr_en);                      // R7

endmodule

bind dbg_capture_unit dbg_capture_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .state    (st_bits),
   .wptr     (wptr),
   .wr_en    (wr_en),
   .trig_hit (trig_hit),
   .qual_hit (qual_hit),
   .en       (en_q)
);

// File: tb/sim_dbg_capture_unit.sv
module sim_dbg_capture_unit;

   localparam int GROUPS = 16;
   localparam int GW     = 8;
   localparam int DEPTH  = 16;

   localparam logic [3:0] A_CTRL = 0, A_GSEL = 1, A_WLEN = 2, A_TMASK = 3, A_TA = 4,
                          A_TB = 5, A_QMASK = 6, A_QA = 7, A_RADDR = 9,
                          A_RDATA = 10, A_STATE = 11, A_WPTR = 12, A_WCOUNT = 13;

   logic                 clk = 1'b0;
   logic                 rst_n;
   logic [GROUPS*GW-1:0] probe;
   logic                 cfg_we;
   logic [3:0]           cfg_addr;
   logic [31:0]          cfg_wdata;
   logic [31:0]          cfg_rdata;

   int        n_chk  = 0;
   int        n_fail = 0;
   bit        done   = 0;
   logic [7:0] exp_q[$];

   always #5 clk = ~clk;

   dbg_capture_unit #(.GROUPS(GROUPS), .GW(GW), .DEPTH(DEPTH)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .probe     (probe),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ctrl(input bit en, input bit rpt, input bit clr,
                                        input int top, input int qop);
      return {21'd0, 1'b0, 3'(qop), 1'b0, 3'(top), 1'b0, clr, rpt, en};
   endfunction

   task automatic wreg(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rreg(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic feed(input int v);
      @(negedge clk);
      for (int g = 0; g < GROUPS; g++) probe[g*GW +: GW] = 8'(v + g);
   endtask

   task automatic push_exp(input logic [7:0] v);
      exp_q.push_back(v);
   endtask

   task automatic status(input string tag, input int st, input int ptr, input int wc);
      logic [31:0] d;
      rreg(A_STATE, d);  check({tag, " state"}, d, st);
      rreg(A_WPTR, d);   check({tag, " wptr"}, d, ptr);
      rreg(A_WCOUNT, d); check({tag, " windows"}, d, wc);
   endtask

   // monitor side of the scoreboard: read the buffer back and pop expectations
   task automatic drain(input string tag);
      logic [31:0] d;
      int n;
      n = exp_q.size();
      for (int i = 0; i < n; i++) begin
         logic [7:0] e;
         wreg(A_RADDR, i);
         rreg(A_RDATA, d);
         e = exp_q.pop_front();
         check($sformatf("%s sample %0d", tag, i), d, {24'd0, e});
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      probe = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 / R10 reset values
      status("R11 reset", 0, 0, 0);
      rreg(A_WLEN, d); check("R11 window length", d, 1);
      rreg(A_CTRL, d); check("R11 control", d, 32'h600);

      // R1 R2 R3(equal) R5 single shot on group 3
      wreg(A_GSEL, 3); wreg(A_TMASK, 8'hFF); wreg(A_TA, 8'h23); wreg(A_WLEN, 4);
      wreg(A_CTRL, ctrl(1, 0, 0, 0, 6));
      for (int v = 8'h10; v <= 8'h2F; v++) feed(v);
      @(negedge clk);
      status("R5 single shot", 0, 4, 1);
      for (int v = 8'h23; v <= 8'h26; v++) push_exp(8'(v));
      drain("R2 R1 trigger window");

      // R9 clear
      wreg(A_CTRL, ctrl(0, 0, 1, 0, 6));
      status("R9 clear", 0, 0, 0);

      // R4 R5 R6 R3(greater): repeat with even-only qualifier until full
      wreg(A_GSEL, 0); wreg(A_TA, 8'h40); wreg(A_QMASK, 8'h01); wreg(A_QA, 0);
      wreg(A_WLEN, 3);
      wreg(A_CTRL, ctrl(1, 1, 0, 3, 0));
      for (int v = 8'h38; v <= 8'h60; v++) feed(v);
      feed(8'h62); feed(8'h64);
      @(negedge clk);
      status("R6 full", 3, 16, 5);
      for (int v = 8'h42; v <= 8'h60; v += 2) push_exp(8'(v));
      drain("R4 qualified repeat");

      // R3 inside range, inclusive bounds, R5 appended windows
      wreg(A_CTRL, ctrl(0, 0, 1, 0, 6));
      wreg(A_TA, 8'h30); wreg(A_TB, 8'h32); wreg(A_WLEN, 2);
      wreg(A_CTRL, ctrl(1, 1, 0, 4, 6));
      for (int p = 0; p < 2; p++)
         for (int v = 8'h2E; v <= 8'h3F; v++) feed(v);
      @(negedge clk);
      status("R5 appended", 1, 8, 4);
      wreg(A_CTRL, ctrl(0, 1, 0, 4, 6));
      @(negedge clk);
      for (int p = 0; p < 2; p++)
         for (int v = 8'h30; v <= 8'h33; v++) push_exp(8'(v));
      drain("R3 inside range");

      // R3 outside range
      wreg(A_CTRL, ctrl(0, 0, 1, 0, 6));
      wreg(A_TA, 8'h01); wreg(A_TB, 8'hFE); wreg(A_WLEN, 1);
      wreg(A_CTRL, ctrl(1, 1, 0, 5, 6));
      feed(8'hFD); feed(8'hFE); feed(8'hFF); feed(8'h00); feed(8'h01); feed(8'h02);
      @(negedge clk);
      status("R3 outside", 1, 2, 2);
      wreg(A_CTRL, ctrl(0, 1, 0, 5, 6));
      @(negedge clk);
      push_exp(8'hFF); push_exp(8'h00);
      drain("R3 outside range");

      // R7 disabled unit ignores triggers, then R3 not-equal
      wreg(A_CTRL, ctrl(0, 0, 1, 0, 6));
      feed(0);
      wreg(A_TA, 0);
      wreg(A_CTRL, ctrl(0, 0, 0, 1, 6));
      feed(7); feed(8);
      @(negedge clk);
      status("R7 disabled", 0, 0, 0);
      feed(0);
      wreg(A_CTRL, ctrl(1, 0, 0, 1, 6));
      feed(0); feed(0); feed(9); feed(3);
      @(negedge clk);
      status("R7 enabled", 0, 1, 1);
      push_exp(8'h09);
      drain("R3 not equal");

      // R3 less-than qualifier, bit trigger on group 5, R8 read gating
      wreg(A_CTRL, ctrl(0, 0, 1, 0, 6));
      feed(8'h70);
      wreg(A_GSEL, 5); wreg(A_TMASK, 8'h80); wreg(A_TA, 8'h80);
      wreg(A_QMASK, 8'hFF); wreg(A_QA, 8'h81); wreg(A_WLEN, 2);
      wreg(A_CTRL, ctrl(1, 0, 0, 0, 2));
      for (int v = 8'h79; v <= 8'h80; v++) feed(v);
      @(negedge clk);
      status("R3 less-than", 2, 1, 0);
      wreg(A_RADDR, 0);
      rreg(A_RDATA, d); check("R8 read while capturing", d, 0);
      wreg(A_CTRL, ctrl(0, 0, 0, 0, 2));
      @(negedge clk); @(negedge clk);
      status("R7 disable stops", 0, 1, 0);
      push_exp(8'h80);
      drain("R8 read after stop");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule